// File: doc/BRIEF.md
# Layer-3/Layer-4 Packet Filter Entry

This block is a single receive filter entry. It watches an Ethernet byte stream, works out whether each frame carries IPv4 or IPv6, picks out the transport protocol number, one 32-bit address word for source and destination, and the TCP/UDP source and destination ports. It then issues one registered verdict per frame that says whether the frame satisfies the configured comparisons.

Each of the four comparisons has its own enable and invert bit. The comparisons are source address, destination address, source port and destination port. Two selector bits choose the expected network-layer and transport-layer protocols. A global enable gates the whole entry.

The parser handles fixed headers only. It assumes a 20-byte IPv4 header, no IPv6 extension headers and no VLAN tag. Several entries can be placed side by side, fed by the same stream, and their verdicts combined downstream.

Top module: `l3l4_filter_entry`

## Requirements
- R1: When `cfg_glob_en` is low, every verdict reports `res_match` = 0. A verdict is still issued.
- R2: `cfg_ctrl` has these bits: bit0 IPv6 select, bit1 source address enable, bit2 source address invert, bit3 destination address enable, bit4 destination address invert, bit5 UDP select, bit6 source port enable, bit7 source port invert, bit8 destination port enable, bit9 destination port invert. If bits 1, 3, 6 and 8 are all zero, the entry is inactive and reports no match. An all-zero word is one such case.
- R3: The EtherType is read from bytes 12–13, most significant byte first. 0x0800 means IPv4 and 0x86DD means IPv6. When the frame's network layer differs from the one selected by bit0, or the EtherType is neither value, every enabled comparison fails.
- R4: For IPv4, the source address is bytes 26–29 and the destination address is bytes 30–33, big-endian. They are compared with `cfg_l3_src` and `cfg_l3_dst`. With the invert bit set, a comparison passes when the values differ.
- R5: For IPv6, only the least significant 32 bits of each address are compared. These are bytes 34–37 for the source and bytes 50–53 for the destination. If both address enables are set in IPv6 mode, the source comparison wins and the destination comparison is treated as disabled.
- R6: The protocol byte is at offset 23 for IPv4 and 20 for IPv6. Bit5 set expects UDP (17) and bit5 clear expects TCP (6). On a mismatch, enabled port comparisons fail; address comparisons are unaffected.
- R7: The ports start at the transport header, which is offset 34 for IPv4 and 54 for IPv6. The source port comes first, then the destination port, both big-endian. They are compared with `cfg_l4_ports[15:0]` and `cfg_l4_ports[31:16]` respectively, each with its own invert bit.
- R8: `res_match` is 1 only when the entry is active and every enabled comparison passes.
- R9: Each frame yields exactly one single-cycle `res_valid` pulse. It comes two clock cycles after the byte that completes the header: byte 37 for IPv4, byte 57 for IPv6, byte 13 for any other EtherType. Later bytes of the frame are ignored.
- R10: A frame that ends before its deciding byte yields no verdict. A byte presented with `rx_sof` restarts parsing at offset 0.
- R11: After a synchronous reset both outputs are low, and `res_match` is never high without `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_glob_en | input | 1 | Global enable for layer-3/4 filtering |
| cfg_ctrl | input | 10 | Entry control word (see R2) |
| cfg_l3_src | input | 32 | Source address match value |
| cfg_l3_dst | input | 32 | Destination address match value |
| cfg_l4_ports | input | 32 | Destination port [31:16], source port [15:0] |
| rx_sof | input | 1 | Marks byte 0 of a frame; valid only with `rx_valid` |
| rx_valid | input | 1 | Byte strobe |
| rx_data | input | 8 | Frame byte |
| res_valid | output | 1 | Verdict strobe, one per parsed frame |
| res_match | output | 1 | Verdict: frame matches the entry |

## Verification
The checks assume three things about the inputs. First, the configuration inputs stay constant from the first byte of a frame until its verdict has appeared. Second, `rx_sof` is only raised together with `rx_valid`. Third, a verdict can only follow a byte accepted two cycles earlier.

The stimulus changes configuration only after each frame's verdict has been consumed, plus idle cycles. It always pairs the start marker with a valid byte. Frames are sent either back to back or with idle gaps, so that verdict timing does not depend on a continuous stream.

// File: rtl/l3l4_pkg.sv
package l3l4_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 32;
  localparam int PORT_W  = 16;
  localparam int ADDR_B  = ADDR_W / BYTE_W;
  localparam int PORT_B  = PORT_W / BYTE_W;

  localparam logic [15:0] ET_IPV4 = 16'h0800;
  localparam logic [15:0] ET_IPV6 = 16'h86DD;
  localparam logic [7:0]  PR_TCP  = 8'd6;
  localparam logic [7:0]  PR_UDP  = 8'd17;

  localparam int TYPE_OFF  = 12;
  localparam int ETH_HDR   = 14;
  localparam int V4_PROTO  = ETH_HDR + 9;
  localparam int V4_SRC    = ETH_HDR + 12;
  localparam int V4_DST    = ETH_HDR + 16;
  localparam int V4_L4     = ETH_HDR + 20;
  localparam int V6_PROTO  = ETH_HDR + 6;
  localparam int V6_SRC    = ETH_HDR + 8 + 16 - ADDR_B;
  localparam int V6_DST    = ETH_HDR + 24 + 16 - ADDR_B;
  localparam int V6_L4     = ETH_HDR + 40;
  localparam int LAST_OFF  = V6_L4 + 2 * PORT_B - 1;
  localparam int OFF_W     = $clog2(LAST_OFF + 2);

  localparam int CTRL_W    = 10;
  localparam int C_IP6     = 0;
  localparam int C_SA_EN   = 1;
  localparam int C_SA_INV  = 2;
  localparam int C_DA_EN   = 3;
  localparam int C_DA_INV  = 4;
  localparam int C_UDP     = 5;
  localparam int C_SP_EN   = 6;
  localparam int C_SP_INV  = 7;
  localparam int C_DP_EN   = 8;
  localparam int C_DP_INV  = 9;

  typedef enum logic [1:0] {FK_NONE, FK_V4, FK_V6, FK_OTHER} frame_kind_e;

  typedef struct packed {
    frame_kind_e       kind;
    logic [7:0]        proto;
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
    logic [PORT_W-1:0] sport;
    logic [PORT_W-1:0] dport;
  } hdr_t;
endpackage

// File: rtl/l3l4_hdr_parser.sv
module l3l4_hdr_parser
  import l3l4_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_sof,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output hdr_t              hdr,
  output logic              hdr_done
);
  logic              busy;
  logic [OFF_W-1:0]  off;
  logic [OFF_W-1:0]  cur_off;
  logic [BYTE_W-1:0] type_hi;
  logic              take;
  logic [OFF_W-1:0]  o_proto, o_src, o_dst, o_l4;
  logic [15:0]       etype;

  always_comb begin
    cur_off = in_sof ? '0 : off;
    take    = in_valid & (in_sof | busy);
    etype   = {type_hi, in_data};
    if (hdr.kind == FK_V6) begin
      o_proto = OFF_W'(V6_PROTO);
      o_src   = OFF_W'(V6_SRC);
      o_dst   = OFF_W'(V6_DST);
      o_l4    = OFF_W'(V6_L4);
    end else begin
      o_proto = OFF_W'(V4_PROTO);
      o_src   = OFF_W'(V4_SRC);
      o_dst   = OFF_W'(V4_DST);
      o_l4    = OFF_W'(V4_L4);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      off      <= '0;
      type_hi  <= '0;
      hdr      <= '0;
      hdr_done <= 1'b0;
    end else begin
      hdr_done <= 1'b0;
      if (take) begin
        busy <= 1'b1;
        off  <= cur_off + 1'b1;
        if (cur_off == OFF_W'(TYPE_OFF))
          type_hi <= in_data;
        if (cur_off == OFF_W'(TYPE_OFF + 1)) begin
          if (etype == ET_IPV4)      hdr.kind <= FK_V4;
          else if (etype == ET_IPV6) hdr.kind <= FK_V6;
          else begin
            hdr.kind <= FK_OTHER;
            busy     <= 1'b0;
            hdr_done <= 1'b1;
          end
        end
        if (cur_off == o_proto)
          hdr.proto <= in_data;
        if (cur_off >= o_src && cur_off < o_src + OFF_W'(ADDR_B))
          hdr.src <= {hdr.src[ADDR_W-BYTE_W-1:0], in_data};
        if (cur_off >= o_dst && cur_off < o_dst + OFF_W'(ADDR_B))
          hdr.dst <= {hdr.dst[ADDR_W-BYTE_W-1:0], in_data};
        if (cur_off >= o_l4 && cur_off < o_l4 + OFF_W'(PORT_B))
          hdr.sport <= {hdr.sport[PORT_W-BYTE_W-1:0], in_data};
        if (cur_off >= o_l4 + OFF_W'(PORT_B) && cur_off < o_l4 + OFF_W'(2 * PORT_B))
          hdr.dport <= {hdr.dport[PORT_W-BYTE_W-1:0], in_data};
        if (cur_off == o_l4 + OFF_W'(2 * PORT_B - 1)) begin
          busy     <= 1'b0;
          hdr_done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/l3l4_field_cmp.sv
module l3l4_field_cmp #(
  parameter int W = 32
) (
  input  logic         en,
  input  logic         inv,
  input  logic         type_ok,
  input  logic [W-1:0] field,
  input  logic [W-1:0] ref_val,
  output logic         pass
);
  always_comb
    pass = ~en | (type_ok & ((field == ref_val) ^ inv));
endmodule

// File: rtl/l3l4_filter_entry.sv
module l3l4_filter_entry
  import l3l4_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_glob_en,
  input  logic [CTRL_W-1:0] cfg_ctrl,
  input  logic [ADDR_W-1:0] cfg_l3_src,
  input  logic [ADDR_W-1:0] cfg_l3_dst,
  input  logic [2*PORT_W-1:0] cfg_l4_ports,
  input  logic              rx_sof,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              res_valid,
  output logic              res_match
);
  hdr_t hdr;
  logic hdr_done;
  logic active, l3_ok, l4_ok, da_en_eff;
  logic [1:0][ADDR_W-1:0] a_fld, a_ref;
  logic [1:0][PORT_W-1:0] p_fld, p_ref;
  logic [1:0] a_en, a_inv, a_pass, p_en, p_inv, p_pass;

  l3l4_hdr_parser u_parser (
    .clk      (clk),
    .rst      (rst),
    .in_sof   (rx_sof),
    .in_valid (rx_valid),
    .in_data  (rx_data),
    .hdr      (hdr),
    .hdr_done (hdr_done)
  );

  always_comb begin
    active    = cfg_glob_en & (cfg_ctrl[C_SA_EN] | cfg_ctrl[C_DA_EN] |
                               cfg_ctrl[C_SP_EN] | cfg_ctrl[C_DP_EN]);
    l3_ok     = (hdr.kind == FK_V6 &&  cfg_ctrl[C_IP6]) ||
                (hdr.kind == FK_V4 && !cfg_ctrl[C_IP6]);
    l4_ok     = l3_ok && (hdr.proto == (cfg_ctrl[C_UDP] ? PR_UDP : PR_TCP));
    da_en_eff = cfg_ctrl[C_DA_EN] & ~(cfg_ctrl[C_IP6] & cfg_ctrl[C_SA_EN]);
    a_fld     = {hdr.dst, hdr.src};
    a_ref     = {cfg_l3_dst, cfg_l3_src};
    a_en      = {da_en_eff, cfg_ctrl[C_SA_EN]};
    a_inv     = {cfg_ctrl[C_DA_INV], cfg_ctrl[C_SA_INV]};
    p_fld     = {hdr.dport, hdr.sport};
    p_ref     = {cfg_l4_ports[2*PORT_W-1:PORT_W], cfg_l4_ports[PORT_W-1:0]};
    p_en      = {cfg_ctrl[C_DP_EN], cfg_ctrl[C_SP_EN]};
    p_inv     = {cfg_ctrl[C_DP_INV], cfg_ctrl[C_SP_INV]};
  end

  for (genvar g = 0; g < 2; g++) begin : g_cmp
    l3l4_field_cmp #(.W(ADDR_W)) u_addr (
      .en (a_en[g]), .inv (a_inv[g]), .type_ok (l3_ok),
      .field (a_fld[g]), .ref_val (a_ref[g]), .pass (a_pass[g])
    );
    l3l4_field_cmp #(.W(PORT_W)) u_port (
      .en (p_en[g]), .inv (p_inv[g]), .type_ok (l4_ok),
      .field (p_fld[g]), .ref_val (p_ref[g]), .pass (p_pass[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_match <= 1'b0;
    end else begin
      res_valid <= hdr_done;
      res_match <= hdr_done & active & (&a_pass) & (&p_pass);
    end
  end
endmodule

// File: rtl/l3l4_filter_entry_chk.sv
module l3l4_filter_entry_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfg_glob_en,
  input logic [3:0] ctrl_en_bits,
  input logic       rx_valid,
  input logic       res_valid,
  input logic       res_match
);
  // R11
  match_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    res_match |-> res_valid);

  // R1
  glob_off_no_match_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !cfg_glob_en) |-> !res_match);

  // R2
  inactive_no_match_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && ctrl_en_bits == 4'b0000) |-> !res_match);

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  // R9
  byte_before_verdict_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(rx_valid, 2));
endmodule

bind l3l4_filter_entry l3l4_filter_entry_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_glob_en  (cfg_glob_en),
  .ctrl_en_bits ({cfg_ctrl[8], cfg_ctrl[6], cfg_ctrl[3], cfg_ctrl[1]}),
  .rx_valid     (rx_valid),
  .res_valid    (res_valid),
  .res_match    (res_match)
);

// File: tb/l3l4_filter_entry_tb.sv
`timescale 1ns/1ps
module l3l4_filter_entry_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_glob_en = 1'b0;
  logic [9:0]  cfg_ctrl = '0;
  logic [31:0] cfg_l3_src = '0, cfg_l3_dst = '0, cfg_l4_ports = '0;
  logic        rx_sof = 1'b0, rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        res_valid, res_match;

  always #2.5 clk = ~clk;

  l3l4_filter_entry u_dut (
    .clk (clk), .rst (rst), .cfg_glob_en (cfg_glob_en), .cfg_ctrl (cfg_ctrl),
    .cfg_l3_src (cfg_l3_src), .cfg_l3_dst (cfg_l3_dst), .cfg_l4_ports (cfg_l4_ports),
    .rx_sof (rx_sof), .rx_valid (rx_valid), .rx_data (rx_data),
    .res_valid (res_valid), .res_match (res_match)
  );

  int n_chk = 0, n_fail = 0, r11_bad = 0;
  bit    exp_q[$];
  string tag_q[$];
  logic [7:0] fr [0:63];
  int fr_len;
  int f_kind; logic [7:0] f_proto; logic [31:0] f_src, f_dst; logic [15:0] f_sp, f_dp;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (res_match && !res_valid) r11_bad++;
      if (res_valid) begin
        if (exp_q.size() == 0)
          check(1'b0, "R9 unexpected verdict", 32'(res_match), 32'd0);
        else begin
          automatic bit e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check(res_match == e, t, 32'(res_match), 32'(e));
        end
      end
    end
  end

  function automatic bit model();
    bit en, l3ok, l4ok, daen, r;
    en = cfg_ctrl[1] | cfg_ctrl[3] | cfg_ctrl[6] | cfg_ctrl[8];
    if (!cfg_glob_en || !en) return 1'b0;
    l3ok = (f_kind == 6 && cfg_ctrl[0]) || (f_kind == 4 && !cfg_ctrl[0]);
    l4ok = l3ok && (f_proto == (cfg_ctrl[5] ? 8'd17 : 8'd6));
    daen = cfg_ctrl[3] && !(cfg_ctrl[0] && cfg_ctrl[1]);
    r = 1'b1;
    if (cfg_ctrl[1]) r &= l3ok && ((f_src == cfg_l3_src) != cfg_ctrl[2]);
    if (daen)        r &= l3ok && ((f_dst == cfg_l3_dst) != cfg_ctrl[4]);
    if (cfg_ctrl[6]) r &= l4ok && ((f_sp == cfg_l4_ports[15:0]) != cfg_ctrl[7]);
    if (cfg_ctrl[8]) r &= l4ok && ((f_dp == cfg_l4_ports[31:16]) != cfg_ctrl[9]);
    return r;
  endfunction

  task automatic build(input int kind, input logic [7:0] proto, input logic [31:0] src,
                       input logic [31:0] dst, input logic [15:0] sp, input logic [15:0] dp);
    f_kind = kind; f_proto = proto; f_src = src; f_dst = dst; f_sp = sp; f_dp = dp;
    for (int i = 0; i < 64; i++) fr[i] = 8'hA5;
    if (kind == 4) begin
      fr[12] = 8'h08; fr[13] = 8'h00; fr[14] = 8'h45; fr[23] = proto;
      for (int i = 0; i < 4; i++) begin
        fr[26+i] = src[31-8*i -: 8];
        fr[30+i] = dst[31-8*i -: 8];
      end
      fr[34] = sp[15:8]; fr[35] = sp[7:0]; fr[36] = dp[15:8]; fr[37] = dp[7:0];
      fr_len = 42;
    end else if (kind == 6) begin
      fr[12] = 8'h86; fr[13] = 8'hDD; fr[14] = 8'h60; fr[20] = proto;
      for (int i = 0; i < 4; i++) begin
        fr[34+i] = src[31-8*i -: 8];
        fr[50+i] = dst[31-8*i -: 8];
      end
      fr[54] = sp[15:8]; fr[55] = sp[7:0]; fr[56] = dp[15:8]; fr[57] = dp[7:0];
      fr_len = 62;
    end else begin
      fr[12] = 8'h88; fr[13] = 8'hB5;
      fr_len = 20;
    end
  endtask

  task automatic send(input int len, input int gap);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = (i == 0); rx_data = fr[i];
      for (int k = 0; k < gap; k++) begin
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0;
      end
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0;
  endtask

  task automatic run(input string tag, input int gap);
    exp_q.push_back(model());
    tag_q.push_back(tag);
    send(fr_len, gap);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(res_valid == 1'b0 && res_match == 1'b0, "R11 reset outputs", {res_valid, res_match}, 0);

    cfg_glob_en = 1'b1; cfg_l3_src = 32'hC0A80105; cfg_l3_dst = 32'h0A000001;
    cfg_l4_ports = {16'd443, 16'd5000};

    // R4 source address, IPv4, TCP
    cfg_ctrl = 10'b00_0000_0010;
    build(4, 8'd6, 32'hC0A80105, 32'h0A000001, 16'd5000, 16'd443); run("R4 sa match", 0);
    build(4, 8'd6, 32'hC0A80106, 32'h0A000001, 16'd5000, 16'd443); run("R4 sa mismatch", 0);
    cfg_ctrl = 10'b00_0000_0110; run("R4 sa inverted differs", 0);
    cfg_ctrl = 10'b00_0000_1000;
    build(4, 8'd6, 32'h01020304, 32'h0A000001, 16'd1, 16'd2); run("R4 da match", 0);
    // R1 global off
    cfg_glob_en = 1'b0; cfg_ctrl = 10'b00_0000_1000; run("R1 global disabled", 0);
    cfg_glob_en = 1'b1;
    // R2 inactive entry
    cfg_ctrl = 10'b00_0000_0000; run("R2 zero control word", 0);
    cfg_ctrl = 10'b10_1011_0101; run("R2 only inverts/selects", 0);
    // R3 network-layer mismatch
    cfg_ctrl = 10'b00_0000_0010;
    build(6, 8'd6, 32'hC0A80105, 32'h0A000001, 16'd5000, 16'd443); run("R3 ipv6 frame ipv4 selected", 0);
    cfg_ctrl = 10'b00_0000_0110; run("R3 mismatch fails even inverted", 0);
    build(0, 8'd6, 0, 0, 0, 0); cfg_ctrl = 10'b00_0000_0010; run("R3 non-IP ethertype", 0);
    // R5 IPv6
    cfg_ctrl = 10'b00_0000_0011;
    build(6, 8'd6, 32'hC0A80105, 32'h0A000001, 16'd5000, 16'd443); run("R5 ipv6 sa low word", 0);
    cfg_ctrl = 10'b00_0000_1011;
    build(6, 8'd6, 32'hC0A80105, 32'hDEADBEEF, 16'd5000, 16'd443); run("R5 sa wins, da ignored", 0);
    cfg_ctrl = 10'b00_0000_1001;
    build(6, 8'd6, 32'h0, 32'h0A000001, 16'd5000, 16'd443); run("R5 ipv6 da low word", 0);
    // R6 transport protocol
    cfg_ctrl = 10'b00_0110_0000;
    build(4, 8'd6, 32'h0, 32'h0, 16'd5000, 16'd443); run("R6 udp selected tcp frame", 0);
    build(4, 8'd17, 32'h0, 32'h0, 16'd5000, 16'd443); run("R6 udp frame", 0);
    cfg_ctrl = 10'b00_0110_0010;
    build(4, 8'd6, 32'hC0A80105, 32'h0, 16'd5000, 16'd443); run("R6 addr unaffected, port fails", 0);
    // R7 ports
    cfg_ctrl = 10'b01_0000_0000;
    build(4, 8'd6, 32'h0, 32'h0, 16'd7, 16'd443); run("R7 dport match", 0);
    cfg_ctrl = 10'b11_0000_0000; run("R7 dport inverted equal", 0);
    cfg_ctrl = 10'b00_1100_0001;
    build(6, 8'd6, 32'h0, 32'h0, 16'd5001, 16'd443); run("R7 ipv6 sport inverted differs", 0);
    // R8 all comparisons
    cfg_ctrl = 10'b01_0100_1010;
    build(4, 8'd6, 32'hC0A80105, 32'h0A000001, 16'd5000, 16'd443); run("R8 all pass", 0);
    build(4, 8'd6, 32'hC0A80105, 32'h0A000001, 16'd5000, 16'd444); run("R8 one fails", 0);
    // R9 gaps and latency
    build(4, 8'd6, 32'hC0A80105, 32'h0A000001, 16'd5000, 16'd443); run("R9 gapped stream", 2);
    exp_q.push_back(model()); tag_q.push_back("R9 latency verdict");
    send(38, 0);
    check(res_valid == 1'b0, "R9 no verdict one cycle after last byte", 32'(res_valid), 0);
    @(negedge clk);
    check(res_valid == 1'b1, "R9 verdict two cycles after last byte", 32'(res_valid), 1);
    repeat (4) @(negedge clk);
    // R10 truncated frame then restart
    send(30, 0);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R10 no verdict for short frame", exp_q.size(), 0);
    send(20, 0);
    run("R10 restart after partial", 0);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R9 every expected verdict seen", exp_q.size(), 0);
    check(r11_bad == 0, "R11 match only with valid", r11_bad, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule